// File: doc/BRIEF.md
# Fault Indicator Blink Sequencer

This block turns a set of fault flags into a blink code on one active-low LED pin. Each fault class has its own repeating sequence of high and low segments. Some are symmetric square waves. Others are asymmetric codes, such as one long low followed by short pulses. An LED wired from the pin to a supply lights while the pin is low. With no fault the pin rests high, so the LED is dark.

Segment lengths are counted in ticks of an external time base. `UNIT_TICKS` sets how many ticks make one 10 ms unit, and every duration below is a whole number of such units. When several flags are raised together, a fixed priority picks one class. Whenever the picked class changes, its code restarts from the first segment.

Top module: `fault_blink_top`

## Requirements
- R1: After the synchronous reset, and whenever no flag is set, `pin_n` is 1.
- R2: When the lock flag `fault_flags[0]` is the selected class, `pin_n` stays 0 for as long as that class stays selected.
- R3: The overcurrent class (`fault_flags[1]`) repeats 67 units high, then 67 units low.
- R4: The overtemperature class (`fault_flags[2]`) repeats this sequence: 67 low, 17 high, 8 low, 17 high, 8 low, 17 high.
- R5: The system-error class (`fault_flags[4]`) repeats this sequence: 8 low, 8 high, 8 low, 109 high.
- R6: The overvoltage class (`fault_flags[3]`) repeats 17 units high, then 17 units low.
- R7: The zero-demand class (`fault_flags[5]`) repeats this sequence: 25 high, 8 low, 34 high, 67 low.
- R8: When several flags are set, the lowest-numbered set bit wins. The order is bit 0 (lock), bit 1 (overcurrent), bit 2 (overtemperature), bit 3 (overvoltage), bit 4 (system error), bit 5 (zero demand).
- R9: A clock edge that sees a selected class different from the running one starts the new class at its first segment with zero elapsed ticks, from the next cycle on. A tick in that same cycle is not counted.
- R10: One unit is `UNIT_TICKS` cycles with `tick` high. Elapsed time advances only on cycles where `tick` is 1, and it wraps at the end of the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle time-base pulse |
| fault_flags | input | 6 | Fault flags, bit 0 has the highest priority |
| pin_n | output | 1 | Pin enable, 0 means LED on |

## Verification
A change of the selected class and a time-base tick can arrive on the same clock edge. The restart must win, and the tick must be dropped. The bench provokes this directly: it switches from a running overcurrent code to overvoltage while `tick` is high. The random phase also produces it many times, because flag changes and ticks arrive independently. A reference model in the bench counts elapsed ticks since the last restart and finds the expected level from cumulative segment lengths. It compares that level with `pin_n` every cycle.

// File: rtl/fb_pkg.sv
package fb_pkg;

    localparam int NUM_FAULTS = 6;
    localparam int MAX_SEGS   = 6;
    localparam int MAX_UNITS  = 109;
    localparam int SEG_W      = $clog2(MAX_SEGS);

    typedef enum logic [2:0] {
        FC_NONE = 3'd0,
        FC_LOCK = 3'd1,
        FC_OCP  = 3'd2,
        FC_OTP  = 3'd3,
        FC_OVP  = 3'd4,
        FC_SYS  = 3'd5,
        FC_ZERO = 3'd6
    } fault_cls_e;

    typedef struct packed {
        logic       level;
        logic [7:0] units;
    } seg_t;

    function automatic seg_t mk(input logic lv, input int u);
        seg_t s;
        s.level = lv;
        s.units = 8'(u);
        return s;
    endfunction

    function automatic logic [SEG_W-1:0] seg_count(input fault_cls_e c);
        case (c)
            FC_OCP, FC_OVP:  return SEG_W'(2);
            FC_OTP:          return SEG_W'(6);
            FC_SYS, FC_ZERO: return SEG_W'(4);
            default:         return SEG_W'(1);
        endcase
    endfunction

    function automatic seg_t seg_lookup(input fault_cls_e c, input logic [SEG_W-1:0] i);
        seg_t s;
        s = mk(1'b1, 1);
        case (c)
            FC_LOCK: s = mk(1'b0, 1);
            FC_OCP:  s = (i == 0) ? mk(1'b1, 67) : mk(1'b0, 67);
            FC_OVP:  s = (i == 0) ? mk(1'b1, 17) : mk(1'b0, 17);
            FC_OTP: begin
                if (i == 0)       s = mk(1'b0, 67);
                else if (i[0])    s = mk(1'b1, 17);
                else              s = mk(1'b0, 8);
            end
            FC_SYS: begin
                case (i)
                    SEG_W'(0): s = mk(1'b0, 8);
                    SEG_W'(1): s = mk(1'b1, 8);
                    SEG_W'(2): s = mk(1'b0, 8);
                    default:   s = mk(1'b1, 109);
                endcase
            end
            FC_ZERO: begin
                case (i)
                    SEG_W'(0): s = mk(1'b1, 25);
                    SEG_W'(1): s = mk(1'b0, 8);
                    SEG_W'(2): s = mk(1'b1, 34);
                    default:   s = mk(1'b0, 67);
                endcase
            end
            default: s = mk(1'b1, 1);
        endcase
        return s;
    endfunction

endpackage

// File: rtl/fb_prio.sv
module fb_prio
    import fb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_FAULTS-1:0] flags,
    output fault_cls_e            sel
);
    logic [NUM_FAULTS-1:0] grant;

    generate
        for (genvar i = 0; i < NUM_FAULTS; i++) begin : g_grant
            if (i == 0) begin : g_first
                assign grant[i] = flags[i];
            end else begin : g_rest
                assign grant[i] = flags[i] & ~(|flags[i-1:0]);
            end
        end
    endgenerate

    always_comb begin
        sel = FC_NONE;
        for (int i = 0; i < NUM_FAULTS; i++) begin
            if (grant[i]) sel = fault_cls_e'(3'(i + 1));
        end
    end

    // R8
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && ((flags != '0) == (grant != '0)));

    // R8
    lock_first_chk: assert property (@(posedge clk) disable iff (rst)
        flags[0] |-> sel == FC_LOCK);
endmodule

// File: rtl/fb_seq.sv
module fb_seq
    import fb_pkg::*;
#(
    parameter int UNIT_TICKS = 1,
    localparam int CNT_W = $clog2(MAX_UNITS * UNIT_TICKS + 1)
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  fault_cls_e sel,
    output logic       level
);
    fault_cls_e       cls_q;
    logic [SEG_W-1:0] seg_q;
    logic [CNT_W-1:0] cnt_q;
    seg_t             cur;
    logic [CNT_W-1:0] dur;
    logic             seg_end;
    logic             code_end;

    always_comb begin
        cur      = seg_lookup(cls_q, seg_q);
        dur      = CNT_W'(cur.units) * CNT_W'(UNIT_TICKS);
        seg_end  = (cnt_q == dur - CNT_W'(1));
        code_end = (seg_q == seg_count(cls_q) - SEG_W'(1));
        level    = cur.level;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cls_q <= FC_NONE;
            seg_q <= '0;
            cnt_q <= '0;
        end else if (sel != cls_q) begin
            cls_q <= sel;
            seg_q <= '0;
            cnt_q <= '0;
        end else if (tick) begin
            if (seg_end) begin
                cnt_q <= '0;
                seg_q <= code_end ? '0 : seg_q + SEG_W'(1);
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // R9
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (sel != cls_q) |=> (seg_q == '0 && cnt_q == '0 && cls_q == $past(sel)));

    // R10
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && sel == cls_q) |=> ($stable(seg_q) && $stable(cnt_q)));

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < dur && seg_q < seg_count(cls_q));
endmodule

// File: rtl/fault_blink_top.sv
module fault_blink_top #(
    parameter int UNIT_TICKS = 1
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [5:0] fault_flags,
    output logic       pin_n
);
    import fb_pkg::*;

    fault_cls_e sel;

    fb_prio u_prio (
        .clk   (clk),
        .rst   (rst),
        .flags (fault_flags),
        .sel   (sel)
    );

    fb_seq #(.UNIT_TICKS(UNIT_TICKS)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .sel   (sel),
        .level (pin_n)
    );

    // R2
    lock_low_chk: assert property (@(posedge clk) disable iff (rst)
        (fault_flags[0] && $past(fault_flags[0]) && !$past(rst)) |-> !pin_n);

    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(fault_flags) == '0 && !$past(rst)) |-> pin_n);
endmodule

// File: tb/tb_fault_blink_top.sv
`timescale 1ns/1ps
module tb_fault_blink_top;
    localparam int U = 1;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick;
    logic [5:0] fault_flags;
    logic       pin_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    int mcls  = 0;
    int mel   = 0;

    always #2.5 clk = ~clk;

    fault_blink_top #(.UNIT_TICKS(U)) dut (
        .clk(clk), .rst(rst), .tick(tick),
        .fault_flags(fault_flags), .pin_n(pin_n)
    );

    // bench class numbering: 0 none,1 lock,2 ocp,3 otp,4 ovp,5 sys,6 zero
    function automatic int b_nseg(input int c);
        case (c)
            2, 4: return 2;
            3:    return 6;
            5, 6: return 4;
            default: return 1;
        endcase
    endfunction

    function automatic int b_units(input int c, input int s);
        int t3[6] = '{67, 17, 8, 17, 8, 17};
        int t5[4] = '{8, 8, 8, 109};
        int t6[4] = '{25, 8, 34, 67};
        case (c)
            2: return 67;
            4: return 17;
            3: return t3[s];
            5: return t5[s];
            6: return t6[s];
            default: return 1;
        endcase
    endfunction

    function automatic bit b_level(input int c, input int s);
        case (c)
            0: return 1'b1;
            1: return 1'b0;
            2, 4: return (s == 0);
            3: return (s % 2 == 1);
            5: return (s % 2 == 1);
            6: return (s % 2 == 0);
            default: return 1'b1;
        endcase
    endfunction

    function automatic int b_period(input int c);
        int p = 0;
        for (int s = 0; s < b_nseg(c); s++) p += b_units(c, s) * U;
        return p;
    endfunction

    function automatic bit b_expect(input int c, input int el);
        int acc = 0;
        for (int s = 0; s < b_nseg(c); s++) begin
            acc += b_units(c, s) * U;
            if (el < acc) return b_level(c, s);
        end
        return 1'b1;
    endfunction

    function automatic int b_prio(input logic [5:0] f);
        for (int i = 0; i < 6; i++) if (f[i]) return i + 1;
        return 0;
    endfunction

    function automatic string req_of(input int c);
        case (c)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R6";
            5: return "R5";
            6: return "R7";
            default: return "R1";
        endcase
    endfunction

    task automatic check(input string req);
        bit e;
        e = b_expect(mcls, mel);
        n_chk++;
        if (pin_n !== e) begin
            n_bad++;
            $display("FAIL %s cls=%0d el=%0d pin_n actual=%0b expected=%0b", req, mcls, mel, pin_n, e);
        end
    endtask

    // inputs applied at a falling edge, model advanced for the next rising edge
    task automatic step(input logic [5:0] f, input logic t, input string req);
        int s;
        fault_flags = f;
        tick = t;
        s = b_prio(f);
        if (s != mcls) begin
            mcls = s;
            mel = 0;
        end else if (t) begin
            mel = (mel + 1) % b_period(mcls);
        end
        @(negedge clk);
        check((req == "") ? req_of(mcls) : req);
    endtask

    initial begin
        #(150000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [5:0] f;
        seed = 32'h1F2E3D;
        void'($urandom(seed));
        rst = 1'b1;
        tick = 1'b0;
        fault_flags = 6'b111111;
        repeat (3) @(negedge clk);
        mcls = 0; mel = 0;
        check("R1");
        rst = 1'b0;

        // each class alone, tick every cycle, more than a full code
        for (int c = 1; c <= 6; c++) begin
            step(6'b0, 1'b1, "R1");
            for (int k = 0; k < 300; k++) step(6'(1 << (c - 1)), 1'b1, "");
        end

        // R10: no ticks, level must not move
        for (int k = 0; k < 80; k++) step(6'b000010, 1'b1, "R3");
        for (int k = 0; k < 200; k++) step(6'b000010, 1'b0, "R10");

        // R9: class change with a coincident tick
        step(6'b001000, 1'b1, "R9");
        for (int k = 0; k < 40; k++) step(6'b001000, 1'b1, "R9");

        // R8: every flag set selects lock
        for (int k = 0; k < 30; k++) step(6'b111111, 1'b1, "R8");
        for (int k = 0; k < 30; k++) step(6'b111110, 1'b1, "R8");
        for (int k = 0; k < 150; k++) step(6'b110000, 1'b1, "R8");

        // random phase
        f = 6'b0;
        for (int k = 0; k < 40000; k++) begin
            if ($urandom_range(0, 299) == 0) begin
                if ($urandom_range(0, 1) == 0) f = 6'(1 << $urandom_range(0, 5));
                else f = 6'($urandom_range(0, 63));
            end
            step(f, 1'($urandom_range(0, 1)), "");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule